// File: doc/BRIEF.md
# Two-way set-associative cache

This block is a tiny set-associative cache placed between a processor request port and a block-wide memory port. A 4-bit byte address is decoded into a tag, a set index and a byte offset. Four lines are organised as two sets of two ways, and every line holds one two-byte block. Read hits and write hits are served from the lines. On a miss the controller fetches the whole block from memory into a way of the addressed set. Write misses allocate: the block is fetched first and the written byte is then merged into it.

The write policy is fixed when the block is elaborated. With `WRITE_BACK = 0`, every write also sends the updated block to memory before the response. With `WRITE_BACK = 1`, writes mark the line dirty, and a dirty line is copied out to memory only when a later miss evicts it.

Victim choice is left to the surrounding logic. The cache shows the set under lookup and takes a way number back, which it uses only when both ways of that set are occupied. At the end of each access it reports which set and way were touched, so that an external policy (LRU, FIFO and so on) can keep its own state.

Top module: `cache_2way_sa`

## Requirements
- R1: Address bits [3:2] are the tag, bit [1] is the set and bit [0] is the byte offset. Offset 0 maps to block bits [7:0] and offset 1 maps to bits [15:8]. The memory block address is the tag followed by the set (address bits [3:1]).
- R2: After reset every line is invalid, so the first access to any address makes exactly one memory read.
- R3: A read hit makes no memory request and its response appears in the second cycle after the accepting edge.
- R4: On a miss with an invalid way in the set, the lowest-numbered invalid way is filled and `repl_way_i` is ignored.
- R5: On a miss with both ways valid, the way given on `repl_way_i` during lookup is replaced and the other way stays resident.
- R6: Two blocks that share a set can be resident together, and no more than one way of a set ever matches a tag.
- R7: With write-through, every write (hit or miss) writes the full updated block to its own block address before the response, so memory always matches the processor's view.
- R8: With write-back, a write makes no memory write of its own and memory keeps the old block until eviction.
- R9: With write-back, evicting a dirty line first writes its block to the victim's own block address and then reads the new block. Evicting a clean line makes only the read.
- R10: A write miss fetches the block and merges in the written byte; the other byte of the block keeps its memory value.
- R11: `req_ready_o` is high only while idle. It drops after acceptance, and each accepted request gets exactly one single-cycle response.
- R12: In the response cycle, `use_valid_o` is high together with `use_set_o` and `use_way_o`, which give the set and way that served the access.
- R13: A memory request holds its address, direction and write data stable until `mem_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| req_valid_i | input | 1 | processor request valid |
| req_ready_o | output | 1 | cache idle and able to accept |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 4 | byte address |
| req_wdata_i | input | 8 | write byte |
| rsp_valid_o | output | 1 | one-cycle response strobe |
| rsp_rdata_o | output | 8 | addressed byte after the access |
| repl_set_o | output | 1 | set being looked up |
| repl_way_i | input | 1 | victim way when the set is full |
| use_valid_o | output | 1 | access-complete strobe for the policy |
| use_set_o | output | 1 | set that was accessed |
| use_way_o | output | 1 | way that was accessed |
| mem_req_o | output | 1 | memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = block write, 0 = block read |
| mem_addr_o | output | 3 | block address {tag, set} |
| mem_wdata_o | output | 16 | block written to memory |
| mem_ack_i | input | 1 | one-cycle acknowledge; read data valid with it |
| mem_rdata_i | input | 16 | block read from memory |

## Verification
The properties assume that memory raises `mem_ack_i` for one cycle at a time and only while a request is pending. They also assume that `repl_way_i` is stable through the lookup cycle. The bench's memory model acknowledges one cycle after it sees a request and pulls the acknowledge down for a cycle after each transfer. The bench changes `repl_way_i` only while the cache is idle, and it offers a new request only once both caches have responded, so no request is ever presented while the cache is busy.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_FILL,
    ST_STORE,
    ST_RESPOND
  } cache_state_e;
endpackage

// File: rtl/cache_line_store.sv
module cache_line_store #(
  parameter int SETS       = 2,
  parameter int WAYS       = 2,
  parameter int SET_W      = 1,
  parameter int WAY_W      = 1,
  parameter int TAG_W      = 2,
  parameter int BLK_W      = 16,
  parameter bit KEEP_DIRTY = 1'b1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [SET_W-1:0]            rd_set_i,
  output logic [WAYS-1:0]             rd_valid_o,
  output logic [WAYS-1:0]             rd_dirty_o,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag_o,
  output logic [WAYS-1:0][BLK_W-1:0]  rd_data_o,
  input  logic                        wr_en_i,
  input  logic [SET_W-1:0]            wr_set_i,
  input  logic [WAY_W-1:0]            wr_way_i,
  input  logic [TAG_W-1:0]            wr_tag_i,
  input  logic [BLK_W-1:0]            wr_data_i,
  input  logic                        wr_dirty_i
);
  logic             valid_q [SETS][WAYS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [BLK_W-1:0] data_q  [SETS][WAYS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          valid_q[s][w] <= 1'b0;
    end else if (wr_en_i) begin
      valid_q[wr_set_i][wr_way_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_set_i][wr_way_i]  <= wr_tag_i;
      data_q[wr_set_i][wr_way_i] <= wr_data_i;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_valid_o[w] = valid_q[rd_set_i][w];
    assign rd_tag_o[w]   = tag_q[rd_set_i][w];
    assign rd_data_o[w]  = data_q[rd_set_i][w];
  end

  if (KEEP_DIRTY) begin : g_dirty
    logic dirty_q [SETS][WAYS];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int s = 0; s < SETS; s++)
          for (int w = 0; w < WAYS; w++)
            dirty_q[s][w] <= 1'b0;
      end else if (wr_en_i) begin
        dirty_q[wr_set_i][wr_way_i] <= wr_dirty_i;
      end
    end
    for (genvar w = 0; w < WAYS; w++) begin : g_rdd
      assign rd_dirty_o[w] = dirty_q[rd_set_i][w];
    end
  end else begin : g_no_dirty
    assign rd_dirty_o = '0;
  end
endmodule

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1,
  parameter int TAG_W = 2
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic [WAYS-1:0]            hit_vec_o,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           hit_way_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec_o[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec_o[w]) hit_way_o = WAY_W'(w);
  end
endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAY_W-1:0] repl_way_i,
  output logic [WAY_W-1:0] victim_o
);
  // free way first, lowest index wins; policy input only for a full set
  always_comb begin
    logic found;
    found    = 1'b0;
    victim_o = repl_way_i;
    for (int w = 0; w < WAYS; w++) begin
      if (!valid_i[w] && !found) begin
        victim_o = WAY_W'(w);
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cache_2way_sa.sv
module cache_2way_sa
  import cache_pkg::*;
#(
  parameter int TAG_W      = 2,
  parameter int SET_W      = 1,
  parameter int OFF_W      = 1,
  parameter int WAYS       = 2,
  parameter int WRITE_BACK = 1,
  localparam int ADDR_W    = TAG_W + SET_W + OFF_W,
  localparam int BADDR_W   = TAG_W + SET_W,
  localparam int BLK_W     = 8 << OFF_W,
  localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_we_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [7:0]         req_wdata_i,
  output logic               rsp_valid_o,
  output logic [7:0]         rsp_rdata_o,
  output logic [SET_W-1:0]   repl_set_o,
  input  logic [WAY_W-1:0]   repl_way_i,
  output logic               use_valid_o,
  output logic [SET_W-1:0]   use_set_o,
  output logic [WAY_W-1:0]   use_way_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [BADDR_W-1:0] mem_addr_o,
  output logic [BLK_W-1:0]   mem_wdata_o,
  input  logic               mem_ack_i,
  input  logic [BLK_W-1:0]   mem_rdata_i
);
  localparam int SETS    = 1 << SET_W;
  localparam bit WB_MODE = (WRITE_BACK != 0);

  cache_state_e     state_q;
  logic             we_q;
  logic [TAG_W-1:0] tag_q;
  logic [SET_W-1:0] set_q;
  logic [OFF_W-1:0] off_q;
  logic [7:0]       wdata_q;
  logic [WAY_W-1:0] way_q;
  logic [TAG_W-1:0] vic_tag_q;
  logic [BLK_W-1:0] vic_data_q;
  logic [BLK_W-1:0] blk_q;

  logic [WAYS-1:0]            rd_valid, rd_dirty, hit_vec;
  logic [WAYS-1:0][TAG_W-1:0] rd_tag;
  logic [WAYS-1:0][BLK_W-1:0] rd_data;
  logic                       hit;
  logic [WAY_W-1:0]           hit_way, victim;
  logic                       wr_en, wr_dirty;
  logic [WAY_W-1:0]           wr_way;
  logic [BLK_W-1:0]           wr_data, merged_hit, merged_fill;

  cache_line_store #(
    .SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W),
    .TAG_W(TAG_W), .BLK_W(BLK_W), .KEEP_DIRTY(WB_MODE)
  ) u_store (
    .clk_i, .rst_ni,
    .rd_set_i(set_q), .rd_valid_o(rd_valid), .rd_dirty_o(rd_dirty),
    .rd_tag_o(rd_tag), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_set_i(set_q), .wr_way_i(wr_way),
    .wr_tag_i(tag_q), .wr_data_i(wr_data), .wr_dirty_i(wr_dirty)
  );

  cache_tag_match #(.WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_match (
    .valid_i(rd_valid), .tags_i(rd_tag), .tag_i(tag_q),
    .hit_vec_o(hit_vec), .hit_o(hit), .hit_way_o(hit_way)
  );

  cache_victim_sel #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .valid_i(rd_valid), .repl_way_i(repl_way_i), .victim_o(victim)
  );

  always_comb begin
    merged_hit = rd_data[hit_way];
    if (we_q) merged_hit[{off_q, 3'b000} +: 8] = wdata_q;
    merged_fill = mem_rdata_i;
    if (we_q) merged_fill[{off_q, 3'b000} +: 8] = wdata_q;
  end

  always_comb begin
    wr_en    = 1'b0;
    wr_way   = way_q;
    wr_data  = merged_fill;
    wr_dirty = 1'b0;
    if (state_q == ST_LOOKUP && hit && we_q) begin
      wr_en    = 1'b1;
      wr_way   = hit_way;
      wr_data  = merged_hit;
      wr_dirty = WB_MODE;
    end else if (state_q == ST_FILL && mem_ack_i) begin
      wr_en    = 1'b1;
      wr_dirty = WB_MODE && we_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      we_q       <= 1'b0;
      tag_q      <= '0;
      set_q      <= '0;
      off_q      <= '0;
      wdata_q    <= '0;
      way_q      <= '0;
      vic_tag_q  <= '0;
      vic_data_q <= '0;
      blk_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          we_q    <= req_we_i;
          {tag_q, set_q, off_q} <= req_addr_i;
          wdata_q <= req_wdata_i;
          state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (hit) begin
            way_q   <= hit_way;
            blk_q   <= merged_hit;
            state_q <= (we_q && !WB_MODE) ? ST_STORE : ST_RESPOND;
          end else begin
            way_q      <= victim;
            vic_tag_q  <= rd_tag[victim];
            vic_data_q <= rd_data[victim];
            state_q    <= (WB_MODE && rd_valid[victim] && rd_dirty[victim])
                          ? ST_EVICT : ST_FILL;
          end
        end
        ST_EVICT: if (mem_ack_i) state_q <= ST_FILL;
        ST_FILL: if (mem_ack_i) begin
          blk_q   <= merged_fill;
          state_q <= (we_q && !WB_MODE) ? ST_STORE : ST_RESPOND;
        end
        ST_STORE: if (mem_ack_i) state_q <= ST_RESPOND;
        ST_RESPOND: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_RESPOND);
  assign rsp_rdata_o = blk_q[{off_q, 3'b000} +: 8];
  assign repl_set_o  = set_q;
  assign use_valid_o = (state_q == ST_RESPOND);
  assign use_set_o   = set_q;
  assign use_way_o   = way_q;
  assign mem_req_o   = (state_q == ST_EVICT) || (state_q == ST_FILL) || (state_q == ST_STORE);
  assign mem_we_o    = (state_q == ST_EVICT) || (state_q == ST_STORE);
  assign mem_addr_o  = (state_q == ST_EVICT) ? {vic_tag_q, set_q} : {tag_q, set_q};
  assign mem_wdata_o = (state_q == ST_EVICT) ? vic_data_q : blk_q;
endmodule

// File: rtl/cache_2way_sa_chk.sv
module cache_2way_sa_chk #(
  parameter int WAYS       = 2,
  parameter int BADDR_W    = 3,
  parameter int BLK_W      = 16,
  parameter int WRITE_BACK = 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_ready_i,
  input logic               rsp_valid_i,
  input logic               mem_req_i,
  input logic               mem_we_i,
  input logic               mem_ack_i,
  input logic [BADDR_W-1:0] mem_addr_i,
  input logic [BLK_W-1:0]   mem_wdata_i,
  input logic [BADDR_W-1:0] cap_baddr_i,
  input logic               cap_we_i,
  input logic               in_lookup_i,
  input logic               hit_i,
  input logic [WAYS-1:0]    hit_vec_i
);
  assert_accept_drops_ready_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_i |=> !req_ready_i);

  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_i |-> !mem_req_i && !rsp_valid_i);

  assert_rsp_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |=> !rsp_valid_i && req_ready_i);

  assert_mem_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_ack_i |=> mem_req_i && $stable(mem_addr_i)
                                && $stable(mem_we_i) && $stable(mem_wdata_i));

  assert_unique_hit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_lookup_i |-> $countones(hit_vec_i) <= 1);

  assert_read_hit_fast_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_lookup_i && hit_i && !cap_we_i |=> rsp_valid_i && !mem_req_i);

  if (WRITE_BACK != 0) begin : g_wb
    assert_hit_no_mem_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_lookup_i && hit_i |=> !mem_req_i);
    assert_evict_other_block_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_i && mem_we_i |-> mem_addr_i != cap_baddr_i);
  end else begin : g_wt
    assert_store_own_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_i && mem_we_i |-> mem_addr_i == cap_baddr_i);
    assert_write_hit_stores_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_lookup_i && hit_i && cap_we_i |=> mem_req_i && mem_we_i);
  end
endmodule

bind cache_2way_sa cache_2way_sa_chk #(
  .WAYS(WAYS), .BADDR_W(BADDR_W), .BLK_W(BLK_W), .WRITE_BACK(WRITE_BACK)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_valid_i(req_valid_i), .req_ready_i(req_ready_o), .rsp_valid_i(rsp_valid_o),
  .mem_req_i(mem_req_o), .mem_we_i(mem_we_o), .mem_ack_i(mem_ack_i),
  .mem_addr_i(mem_addr_o), .mem_wdata_i(mem_wdata_o),
  .cap_baddr_i({tag_q, set_q}), .cap_we_i(we_q),
  .in_lookup_i(state_q == cache_pkg::ST_LOOKUP),
  .hit_i(hit), .hit_vec_i(hit_vec)
);

// File: tb/sim_cache_2way_sa.sv
module sim_mem (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [15:0] wdata_i,
  output logic        ack_o,
  output logic [15:0] rdata_o
);
  logic [15:0] mem [8];
  int rd_cnt = 0;
  int wr_cnt = 0;

  initial for (int b = 0; b < 8; b++) mem[b] = {8'h41 + 8'(2*b), 8'h40 + 8'(2*b)};

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      rdata_o <= '0;
    end else if (req_i && !ack_o) begin
      ack_o <= 1'b1;
      if (we_i) begin
        mem[addr_i] <= wdata_i;
        wr_cnt <= wr_cnt + 1;
      end else begin
        rdata_o <= mem[addr_i];
        rd_cnt  <= rd_cnt + 1;
      end
    end else begin
      ack_o <= 1'b0;
    end
  end
endmodule

module sim_cache_2way_sa;
  typedef struct { logic [7:0] data; logic set; logic way; string req; } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic       req_valid = 1'b0, req_we = 1'b0, repl_way = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;

  logic        rdy0, rv0, rs0, uv0, us0, uw0, mr0, mw0, ma0;
  logic        rdy1, rv1, rs1, uv1, us1, uw1, mr1, mw1, ma1;
  logic [7:0]  rd0, rd1;
  logic [2:0]  mad0, mad1;
  logic [15:0] mwd0, mwd1, mrd0, mrd1;

  cache_2way_sa #(.WRITE_BACK(1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(rdy0),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rv0), .rsp_rdata_o(rd0), .repl_set_o(rs0), .repl_way_i(repl_way),
    .use_valid_o(uv0), .use_set_o(us0), .use_way_o(uw0),
    .mem_req_o(mr0), .mem_we_o(mw0), .mem_addr_o(mad0), .mem_wdata_o(mwd0),
    .mem_ack_i(ma0), .mem_rdata_i(mrd0));

  cache_2way_sa #(.WRITE_BACK(0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(rdy1),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rv1), .rsp_rdata_o(rd1), .repl_set_o(rs1), .repl_way_i(repl_way),
    .use_valid_o(uv1), .use_set_o(us1), .use_way_o(uw1),
    .mem_req_o(mr1), .mem_we_o(mw1), .mem_addr_o(mad1), .mem_wdata_o(mwd1),
    .mem_ack_i(ma1), .mem_rdata_i(mrd1));

  sim_mem u_mem0 (.clk_i(clk), .rst_ni(rst_n), .req_i(mr0), .we_i(mw0), .addr_i(mad0),
                  .wdata_i(mwd0), .ack_o(ma0), .rdata_o(mrd0));
  sim_mem u_mem1 (.clk_i(clk), .rst_ni(rst_n), .req_i(mr1), .we_i(mw1), .addr_i(mad1),
                  .wdata_i(mwd1), .ack_o(ma1), .rdata_o(mrd1));

  int total = 0, fails = 0;
  bit done = 0;
  logic [7:0] ref_mem [16];
  exp_t q0[$], q1[$];
  int rsp_n0 = 0, rsp_n1 = 0, rsp_cyc0 = 0, rsp_cyc1 = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitors: pop the scoreboard on each response
  always @(negedge clk) begin
    if (rst_n && rv0) begin
      exp_t e;
      if (q0.size() == 0) check(0, "R11", "wb unexpected response", 1, 0);
      else begin
        e = q0.pop_front();
        check(rd0 == e.data, e.req, "wb read data", int'(rd0), int'(e.data));
        check(uv0 && us0 == e.set && uw0 == e.way, "R12", "wb use set/way",
              int'({uv0, us0, uw0}), int'({1'b1, e.set, e.way}));
      end
      rsp_n0++;
      rsp_cyc0 = cyc;
    end
    if (rst_n && rv1) begin
      exp_t e;
      if (q1.size() == 0) check(0, "R11", "wt unexpected response", 1, 0);
      else begin
        e = q1.pop_front();
        check(rd1 == e.data, e.req, "wt read data", int'(rd1), int'(e.data));
        check(uv1 && us1 == e.set && uw1 == e.way, "R12", "wt use set/way",
              int'({uv1, us1, uw1}), int'({1'b1, e.set, e.way}));
      end
      rsp_n1++;
      rsp_cyc1 = cyc;
    end
  end

  // driver: one access to both caches; er/ew = expected memory reads/writes
  task automatic access(input bit we, input logic [3:0] a, input logic [7:0] d,
                        input bit rw, input bit way, input bit is_hit,
                        input int er0, input int ew0, input int er1, input int ew1,
                        input string req);
    exp_t e;
    int r0, w0, r1, w1, n0, n1, acc;
    @(negedge clk);
    repl_way = rw;
    check(rdy0 && rdy1, "R11", "ready while idle", int'({rdy0, rdy1}), 3);
    r0 = u_mem0.rd_cnt; w0 = u_mem0.wr_cnt;
    r1 = u_mem1.rd_cnt; w1 = u_mem1.wr_cnt;
    n0 = rsp_n0; n1 = rsp_n1;
    if (we) ref_mem[a] = d;
    e.data = ref_mem[a]; e.set = a[1]; e.way = way; e.req = req;
    q0.push_back(e); q1.push_back(e);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    acc = cyc;
    req_valid = 1'b0;
    check(!rdy0 && !rdy1, "R11", "ready dropped after accept", int'({rdy0, rdy1}), 0);
    wait (rsp_n0 > n0 && rsp_n1 > n1);
    check(u_mem0.rd_cnt - r0 == er0, req, "wb memory reads", u_mem0.rd_cnt - r0, er0);
    check(u_mem0.wr_cnt - w0 == ew0, req, "wb memory writes", u_mem0.wr_cnt - w0, ew0);
    check(u_mem1.rd_cnt - r1 == er1, req, "wt memory reads", u_mem1.rd_cnt - r1, er1);
    check(u_mem1.wr_cnt - w1 == ew1, req, "wt memory writes", u_mem1.wr_cnt - w1, ew1);
    // read hit: lookup edge, then respond edge
    if (is_hit && !we) begin
      check(rsp_cyc0 - acc == 1, "R3", "wb hit latency", rsp_cyc0 - acc, 1);
      check(rsp_cyc1 - acc == 1, "R3", "wt hit latency", rsp_cyc1 - acc, 1);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) ref_mem[i] = 8'h40 + 8'(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rdy0 && rdy1 && !rv0 && !rv1 && !mr0 && !mr1, "R11", "reset state",
          int'({rdy0, rdy1, rv0, rv1, mr0, mr1}), 6'h30);
    rst_n = 1'b1;
    //      we  addr   data  rw way hit  wb r/w  wt r/w
    access(0, 4'h0, 8'h00, 1, 0, 0, 1, 0, 1, 0, "R2");   // cold miss, way0 despite rw (R4)
    access(0, 4'h1, 8'h00, 0, 0, 1, 0, 0, 0, 0, "R1");   // high byte of same block
    access(0, 4'h4, 8'h00, 0, 1, 0, 1, 0, 1, 0, "R4");   // second tag in set0 -> way1
    access(0, 4'h0, 8'h00, 0, 0, 1, 0, 0, 0, 0, "R6");
    access(0, 4'h5, 8'h00, 0, 1, 1, 0, 0, 0, 0, "R6");
    access(1, 4'h0, 8'hAA, 0, 0, 1, 0, 0, 0, 1, "R7");   // write hit: wb none, wt store (R8)
    access(0, 4'h0, 8'h00, 0, 0, 1, 0, 0, 0, 0, "R8");
    access(0, 4'h8, 8'h00, 0, 0, 0, 1, 1, 1, 0, "R9");   // dirty way0 evicted
    check(u_mem0.mem[0] == 16'h41AA, "R9", "wb evicted block", int'(u_mem0.mem[0]), 16'h41AA);
    access(0, 4'h5, 8'h00, 0, 1, 1, 0, 0, 0, 0, "R5");   // way1 retained
    access(0, 4'h1, 8'h00, 1, 1, 0, 1, 0, 1, 0, "R9");   // clean way1 replaced: read only
    access(1, 4'h3, 8'h5C, 1, 0, 0, 1, 0, 1, 1, "R10");  // write miss allocate
    access(0, 4'h2, 8'h00, 0, 0, 1, 0, 0, 0, 0, "R10");  // other byte from memory
    access(0, 4'h3, 8'h00, 0, 0, 1, 0, 0, 0, 0, "R10");
    access(1, 4'hB, 8'h77, 0, 1, 0, 1, 0, 1, 1, "R7");
    access(0, 4'hF, 8'h00, 0, 0, 0, 1, 1, 1, 0, "R9");   // dirty tag0 set1 evicted
    check(u_mem0.mem[1] == 16'h5C42, "R9", "wb evicted set1 block", int'(u_mem0.mem[1]), 16'h5C42);
    check(u_mem0.mem[5] == 16'h4B4A, "R8", "wb memory untouched", int'(u_mem0.mem[5]), 16'h4B4A);
    access(0, 4'hB, 8'h00, 1, 1, 1, 0, 0, 0, 0, "R5");
    for (int b = 0; b < 8; b++)
      check(u_mem1.mem[b] == {ref_mem[2*b+1], ref_mem[2*b]}, "R7", "wt memory matches",
            int'(u_mem1.mem[b]), int'({ref_mem[2*b+1], ref_mem[2*b]}));
    check(q0.size() == 0 && q1.size() == 0, "R11", "all responses seen",
          q0.size() + q1.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule